// File: doc/BRIEF.md
# SWD Link Wake and Identification Sequencer

This block brings a debug port that can speak either JTAG or SWD into SWD mode and confirms that the link works. A single-cycle start pulse makes it play a fixed serial script on the data line while it generates the serial clock itself. The script has five parts: a long run of ones that resets the line, a 16-bit code that selects SWD, a second run of ones, a stretch of idle zeros, and a read request for the port's identification register.

After the request the block releases the data line. It reads back a three-bit acknowledge, then 32 data bits and a parity bit, and releases the line for one more turnaround cycle before it finishes. At the end it raises a one-cycle done pulse and reports a success flag. When it succeeds it also presents the identification word; otherwise that word reads as zero. Later register traffic belongs to a separate transaction engine. That engine uses the same clock pacing: data changes on the falling serial clock edge and is captured on the rising edge.

The whole run takes 194 serial clock periods when the acknowledge is good. The serial clock rests high whenever the block is idle.

Top module: `swd_wake_seq`

## Requirements
- R1: After reset the serial clock is high, the data line is released (enable low), and busy, done and success are low with the identification output at zero.
- R2: A start pulse while idle raises busy on the next clock. The serial clock then runs with a period of 2*HALF_DIV system clocks. The data output and its enable change only when the serial clock falls.
- R3: The first 66 bits driven are ones, followed by the 16-bit select code 0xE79E sent least significant bit first.
- R4: After the select code come 50 more ones and then 16 zeros.
- R5: Next comes the request byte 0xA5, sent least significant bit first (line order 1,0,1,0,0,1,0,1).
- R6: The data enable is low from the turnaround bit after the request through the turnaround bit after the parity bit. A run with a good acknowledge spans exactly 194 rising serial clock edges.
- R7: The first acknowledge bit received is bit 0, and only 3'b001 is accepted. Any other value skips the data phase, adds one turnaround bit (161 rising edges in total), and ends with success low and the identification output at zero.
- R8: The 32 data bits arrive least significant bit first, and the bit after them must equal the XOR of the data. When the acknowledge and the parity are both good, success goes high and the identification output equals the received word.
- R9: A parity mismatch ends the run with success low and the identification output at zero.
- R10: Done is high for exactly one clock per run, and busy falls in that same cycle.
- R11: Success and the identification output hold their values while idle, and both clear when the next start pulse is taken.
- R12: A start pulse received while busy has no effect: the run keeps its length and produces one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle request to run the wake script |
| swdio_i | input | 1 | Data line as seen from the target side |
| swclk_o | output | 1 | Generated serial clock, high at rest |
| swdio_o | output | 1 | Data line value driven by the block |
| swdio_oe_o | output | 1 | High when the block drives the data line |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| ok_o | output | 1 | Acknowledge and parity both good on the last run |
| idcode_o | output | 32 | Identification word from the last good run, else zero |

## Verification
The assertions assume that start_i is clean and synchronous to clk. They do not assume that start_i is held low while busy, so a stray pulse during a run is legal stimulus. They also assume that swdio_i changes only while the serial clock is low. The bench's target model follows this by updating its data bit shortly after each falling edge and leaving it alone until the next one. The model sends the acknowledge only after the block has released the line, so the bench exercises the release and the capture separately.

// File: rtl/swd_wake_pkg.sv
package swd_wake_pkg;

   // Script segments, in the order they appear on the line
   typedef enum logic [3:0] {
      SG_RST1, SG_SEL, SG_RST2, SG_IDLE, SG_REQ,
      SG_TRN1, SG_ACK, SG_DATA, SG_PAR, SG_TRN2
   } seg_e;

   localparam logic [15:0] SELECT_CODE = 16'hE79E;
   localparam logic [7:0]  ID_REQUEST  = 8'hA5;
   localparam int          ACK_W       = 3;
   localparam logic [ACK_W-1:0] ACK_GOOD = 3'b001;
   localparam int          WORD_W      = 32;

endpackage

// File: rtl/swd_clk_gen.sv
module swd_clk_gen #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic swclk,
   output logic fall_stb,
   output logic rise_stb
);

   logic edge_due;

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("swd_clk_gen: HALF_DIV must be at least 1");
      end

      if (HALF_DIV == 1) begin : g_direct
         assign edge_due = run;
      end else begin : g_count
         localparam int CW = $clog2(HALF_DIV);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            cnt <= '0;
            else if (!run)                         cnt <= '0;
            else if (cnt == CW'(HALF_DIV - 1))     cnt <= '0;
            else                                   cnt <= cnt + 1'b1;
         end

         assign edge_due = run && (cnt == CW'(HALF_DIV - 1));
      end
   endgenerate

   assign fall_stb = edge_due &&  swclk;
   assign rise_stb = edge_due && !swclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        swclk <= 1'b1;
      else if (!run)     swclk <= 1'b1;
      else if (edge_due) swclk <= !swclk;
   end

   // R2
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fall_stb && rise_stb));

   // R1
   rest_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run && !$past(run) |-> swclk);

endmodule

// File: rtl/swd_bit_src.sv
module swd_bit_src
   import swd_wake_pkg::*;
#(
   parameter int IDX_W = 7
) (
   input  seg_e             seg,
   input  logic [IDX_W-1:0] idx,
   output logic             bit_o,
   output logic             oe_o
);

   always_comb begin
      bit_o = 1'b0;
      oe_o  = 1'b1;
      case (seg)
         SG_RST1, SG_RST2: bit_o = 1'b1;
         SG_SEL:           bit_o = SELECT_CODE[idx[3:0]];
         SG_IDLE:          bit_o = 1'b0;
         SG_REQ:           bit_o = ID_REQUEST[idx[2:0]];
         default: begin
            bit_o = 1'b0;
            oe_o  = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/swd_rx_capture.sv
module swd_rx_capture #(
   parameter int DATA_W = 32,
   parameter int ACK_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              take_ack,
   input  logic              take_data,
   input  logic              din,
   output logic [ACK_W-1:0]  ack_next,
   output logic [DATA_W-1:0] data_q,
   output logic              par_err
);

   logic [ACK_W-1:0] ack_q;

   assign ack_next = {din, ack_q[ACK_W-1:1]};
   assign par_err  = din ^ (^data_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q  <= '0;
         data_q <= '0;
      end else if (clear) begin
         ack_q  <= '0;
         data_q <= '0;
      end else begin
         if (take_ack)  ack_q  <= ack_next;
         if (take_data) data_q <= {din, data_q[DATA_W-1:1]};
      end
   end

   // R7
   no_dual_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(take_ack && take_data));

endmodule

// File: rtl/swd_wake_seq.sv
module swd_wake_seq
   import swd_wake_pkg::*;
#(
   parameter int HALF_DIV = 2,
   parameter int RST1_LEN = 66,
   parameter int RST2_LEN = 50,
   parameter int IDLE_LEN = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        swdio_i,
   output logic        swclk_o,
   output logic        swdio_o,
   output logic        swdio_oe_o,
   output logic        busy_o,
   output logic        done_o,
   output logic        ok_o,
   output logic [31:0] idcode_o
);

   localparam int LONGEST = (RST1_LEN > RST2_LEN) ?
                            ((RST1_LEN > WORD_W) ? RST1_LEN : WORD_W) :
                            ((RST2_LEN > WORD_W) ? RST2_LEN : WORD_W);
   localparam int MAXLEN  = (LONGEST > IDLE_LEN) ? LONGEST : IDLE_LEN;
   localparam int IDX_W   = $clog2(MAXLEN + 1);

   generate
      if (RST1_LEN < 50 || RST2_LEN < 50) begin : g_bad_reset
         $error("swd_wake_seq: line reset runs need at least 50 ones");
      end
      if (IDLE_LEN < 2) begin : g_bad_idle
         $error("swd_wake_seq: idle run must be at least 2 bits");
      end
   endgenerate

   function automatic int seg_len(seg_e s);
      case (s)
         SG_RST1: return RST1_LEN;
         SG_SEL:  return 16;
         SG_RST2: return RST2_LEN;
         SG_IDLE: return IDLE_LEN;
         SG_REQ:  return 8;
         SG_ACK:  return ACK_W;
         SG_DATA: return WORD_W;
         default: return 1;
      endcase
   endfunction

   seg_e             seg, cur_seg;
   logic [IDX_W-1:0] idx, cur_idx;
   logic             fail;
   logic             fall_stb, rise_stb;
   logic             src_bit, src_oe;
   logic [ACK_W-1:0] ack_next;
   logic [WORD_W-1:0] rx_word;
   logic             par_err;
   logic             start_acc, seg_last, finishing, ack_bad;
   seg_e             seg_after;

   assign start_acc = start_i && !busy_o;
   assign seg_last  = (idx == IDX_W'(seg_len(seg) - 1));
   assign seg_after = (seg == SG_TRN2) ? SG_RST1 : seg_e'(seg + 4'd1);
   assign finishing = busy_o && rise_stb && (cur_seg == SG_TRN2);
   assign ack_bad   = (cur_seg == SG_ACK) && (cur_idx == IDX_W'(ACK_W - 1)) &&
                      (ack_next != ACK_GOOD);

   swd_clk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy_o),
      .swclk    (swclk_o),
      .fall_stb (fall_stb),
      .rise_stb (rise_stb)
   );

   swd_bit_src #(.IDX_W(IDX_W)) u_src (
      .seg   (seg),
      .idx   (idx),
      .bit_o (src_bit),
      .oe_o  (src_oe)
   );

   swd_rx_capture #(.DATA_W(WORD_W), .ACK_W(ACK_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (start_acc),
      .take_ack  (busy_o && rise_stb && cur_seg == SG_ACK),
      .take_data (busy_o && rise_stb && cur_seg == SG_DATA),
      .din       (swdio_i),
      .ack_next  (ack_next),
      .data_q    (rx_word),
      .par_err   (par_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o     <= 1'b0;
         done_o     <= 1'b0;
         ok_o       <= 1'b0;
         idcode_o   <= '0;
         fail       <= 1'b0;
         seg        <= SG_RST1;
         idx        <= '0;
         cur_seg    <= SG_TRN2;
         cur_idx    <= '0;
         swdio_o    <= 1'b0;
         swdio_oe_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_acc) begin
            busy_o   <= 1'b1;
            seg      <= SG_RST1;
            idx      <= '0;
            ok_o     <= 1'b0;
            idcode_o <= '0;
            fail     <= 1'b0;
         end else if (busy_o) begin
            if (fall_stb) begin
               swdio_o    <= src_bit;
               swdio_oe_o <= src_oe;
               cur_seg    <= seg;
               cur_idx    <= idx;
               if (seg_last) begin
                  seg <= seg_after;
                  idx <= '0;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            if (rise_stb) begin
               if (ack_bad) begin
                  fail <= 1'b1;
                  seg  <= SG_TRN2;
                  idx  <= '0;
               end
               if (cur_seg == SG_PAR && par_err) fail <= 1'b1;
               if (finishing) begin
                  busy_o     <= 1'b0;
                  done_o     <= 1'b1;
                  ok_o       <= !fail;
                  idcode_o   <= fail ? '0 : rx_word;
                  swdio_o    <= 1'b0;
                  swdio_oe_o <= 1'b0;
               end
            end
         end
      end
   end

   // R2
   drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      swclk_o && $past(swclk_o) |-> $stable(swdio_o) && $stable(swdio_oe_o));

   // R6
   rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && (cur_seg == SG_ACK || cur_seg == SG_DATA || cur_seg == SG_PAR)
      |-> !swdio_oe_o);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R9
   fail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !ok_o |-> idcode_o == '0);

   // R11
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && !start_i |=> $stable(ok_o) && $stable(idcode_o));

   // R12
   busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !finishing |=> busy_o);

endmodule

// File: tb/swd_wake_seq_test.sv
module swd_wake_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        swdio_i = 1'b0;
   logic        swclk_o, swdio_o, swdio_oe_o, busy_o, done_o, ok_o;
   logic [31:0] idcode_o;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;

   // target model settings and observations
   logic        armed = 1'b0;
   logic [2:0]  t_ack = 3'b001;
   logic [31:0] t_data = '0;
   logic        t_flip = 1'b0;
   int rise_cnt, fall_cnt;
   int err_a, err_b, err_c, err_oe, err_per;
   int done_cnt;
   logic busy_at_done;
   time last_rise;

   swd_wake_seq uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .swdio_i    (swdio_i),
      .swclk_o    (swclk_o),
      .swdio_o    (swdio_o),
      .swdio_oe_o (swdio_oe_o),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .ok_o       (ok_o),
      .idcode_o   (idcode_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic summary();
      $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual %0d cycles expected below 200000", cycles);
         summary();
         $finish;
      end
   end

   task automatic check(input bit cond, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!cond) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic exp_bit(input int k);
      if (k < 66)  return 1'b1;
      if (k < 82)  return 1'(16'hE79E >> (k - 66));
      if (k < 132) return 1'b1;
      if (k < 148) return 1'b0;
      return 1'(8'hA5 >> (k - 148));
   endfunction

   // target drives its bit shortly after each falling edge
   always @(negedge swclk_o) begin
      if (armed) begin
         #1;
         if (fall_cnt >= 157 && fall_cnt <= 159)      swdio_i = t_ack[fall_cnt - 157];
         else if (fall_cnt >= 160 && fall_cnt <= 191) swdio_i = t_data[fall_cnt - 160];
         else if (fall_cnt == 192)                    swdio_i = (^t_data) ^ t_flip;
         else                                         swdio_i = 1'b0;
         fall_cnt++;
      end
   end

   // observe the host side on each rising edge
   always @(posedge swclk_o) begin
      if (armed) begin
         if (rise_cnt > 0 && ($time - last_rise) != 2 * HALF * CLK_PERIOD) err_per++;
         last_rise = $time;
         #1;
         if (rise_cnt < 156) begin
            if (!swdio_oe_o) err_oe++;
            if (swdio_o !== exp_bit(rise_cnt)) begin
               if (rise_cnt < 82)       err_a++;
               else if (rise_cnt < 148) err_b++;
               else                     err_c++;
            end
         end else if (swdio_oe_o) begin
            err_oe++;
         end
         rise_cnt++;
      end
   end

   task automatic run_transfer(input logic [2:0] ack, input logic [31:0] data,
                               input logic flip, input int extra_at);
      int post;
      t_ack = ack; t_data = data; t_flip = flip;
      rise_cnt = 0; fall_cnt = 0; err_a = 0; err_b = 0; err_c = 0;
      err_oe = 0; err_per = 0; done_cnt = 0; busy_at_done = 1'b1; post = 0;
      armed = 1'b1;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      check(busy_o === 1'b1, "R2 busy after start", 64'(busy_o), 64'd1);
      check(ok_o === 1'b0 && idcode_o === '0, "R11 results cleared by start",
            {31'd0, ok_o, idcode_o}, 64'd0);
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         start_i = (i == extra_at);
         if (done_o) begin
            done_cnt++;
            busy_at_done = busy_o;
         end
         if (done_cnt > 0) begin
            post++;
            if (post > 12) break;
         end
      end
      start_i = 1'b0;
      armed = 1'b0;
   endtask

   task automatic check_script();
      check(err_a == 0, "R3 reset run and select code bit errors", 64'(err_a), 64'd0);
      check(err_b == 0, "R4 second reset and idle bit errors", 64'(err_b), 64'd0);
      check(err_c == 0, "R5 request byte bit errors", 64'(err_c), 64'd0);
      check(err_oe == 0, "R6 drive enable errors", 64'(err_oe), 64'd0);
      check(err_per == 0, "R2 serial clock period errors", 64'(err_per), 64'd0);
   endtask

   task automatic test_reset();
      check(swclk_o === 1'b1, "R1 serial clock rests high", 64'(swclk_o), 64'd1);
      check(swdio_oe_o === 1'b0, "R1 line released", 64'(swdio_oe_o), 64'd0);
      check({busy_o, done_o, ok_o} === 3'b000, "R1 flags low",
            64'({busy_o, done_o, ok_o}), 64'd0);
      check(idcode_o === '0, "R1 identification zero", 64'(idcode_o), 64'd0);
   endtask

   task automatic test_good(input logic [31:0] word);
      run_transfer(3'b001, word, 1'b0, -1);
      check_script();
      check(rise_cnt == 194, "R6 rising edges on good run", 64'(rise_cnt), 64'd194);
      check(done_cnt == 1, "R10 one done pulse", 64'(done_cnt), 64'd1);
      check(busy_at_done === 1'b0, "R10 busy low at done", 64'(busy_at_done), 64'd0);
      check(ok_o === 1'b1, "R8 success flag", 64'(ok_o), 64'd1);
      check(idcode_o === word, "R8 identification word", 64'(idcode_o), 64'(word));
   endtask

   task automatic test_bad_ack(input logic [2:0] ack);
      run_transfer(ack, 32'hDEAD_BEEF, 1'b0, -1);
      check(err_a == 0 && err_b == 0 && err_c == 0, "R7 script before bad ack",
            64'(err_a + err_b + err_c), 64'd0);
      check(rise_cnt == 161, "R7 rising edges on bad ack", 64'(rise_cnt), 64'd161);
      check(done_cnt == 1, "R7 done on bad ack", 64'(done_cnt), 64'd1);
      check(ok_o === 1'b0, "R7 success low", 64'(ok_o), 64'd0);
      check(idcode_o === '0, "R7 identification zero", 64'(idcode_o), 64'd0);
   endtask

   task automatic test_parity();
      run_transfer(3'b001, 32'h1234_5678, 1'b1, -1);
      check(rise_cnt == 194, "R9 rising edges on parity error", 64'(rise_cnt), 64'd194);
      check(ok_o === 1'b0, "R9 success low", 64'(ok_o), 64'd0);
      check(idcode_o === '0, "R9 identification zero", 64'(idcode_o), 64'd0);
   endtask

   task automatic test_hold();
      logic [31:0] held;
      logic        held_ok;
      held = idcode_o; held_ok = ok_o;
      repeat (60) @(negedge clk);
      check(ok_o === held_ok && idcode_o === held, "R11 results held while idle",
            {31'd0, ok_o, idcode_o}, {31'd0, held_ok, held});
   endtask

   task automatic test_start_while_busy();
      run_transfer(3'b001, 32'h0BB1_1477, 1'b0, 200);
      check(rise_cnt == 194, "R12 run length unchanged", 64'(rise_cnt), 64'd194);
      check(done_cnt == 1, "R12 single done pulse", 64'(done_cnt), 64'd1);
      check(idcode_o === 32'h0BB1_1477, "R12 result intact", 64'(idcode_o),
            64'h0BB1_1477);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      test_reset();
      test_good(32'h2BA0_1477);
      test_hold();
      test_good(32'h8000_0001);
      test_bad_ack(3'b010);
      test_bad_ack(3'b100);
      test_good(32'hFFFF_FFFE);
      test_parity();
      test_hold();
      test_start_while_busy();
      summary();
      $finish;
   end

endmodule